// File: doc/BRIEF.md
# Settings Write Router

This block sits between the point where a host delivers settings writes and a set of settings modules spread across a chip. Each incoming host word carries three fields: a module index, a register index and a 32-bit value. The router splits the word. It places the register index and the value on an address bus and a data bus that every module shares. It then strobes the one select line that belongs to the addressed module.

A module may take a write only while its ready input reports that its logic has been parked in a safe state. While the addressed module is busy, the router holds the host off by keeping host ready low. The write goes through in the first cycle the module reports safe. A write whose module index names no existing module is accepted at once and thrown away, and no select line is raised.

The shared bus has the same shape however many registers a module holds and however wide they are. The block is purely combinational from the host handshake to the bus, so a write lands in the same cycle it is accepted.

Top module: `cfg_bus_router`

## Requirements
- R1: The host word is laid out as {module index [42:40], register index [39:32], value [31:0]}. `busAddr` always equals the register index field and `busData` always equals the value field.
- R2: `busSelect[k]` is high in a cycle exactly when `hostValid` is high, the module index equals k (k < NUM_MODULES), `modReady[k]` is high and reset is low.
- R3: For a module index below NUM_MODULES and with reset low, `hostReady` equals `modReady` of the addressed module, whatever the other modules report.
- R4: While the addressed module's ready is low, no select line is raised and `hostReady` stays low, so a held write goes out only in the cycle that module's ready goes high.
- R5: A module index of NUM_MODULES or more makes `hostReady` high with reset low, and no select line is raised; the write is discarded.
- R6: At most one select line is high in any cycle.
- R7: With `hostValid` low, no select line is raised.
- R8: While the synchronous active-high reset `rst` is high, all select lines are low and `hostReady` is low.
- R9: A select line is never high while the matching module's ready input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostData | input | 43 | Host word: module index, register index, value |
| hostValid | input | 1 | Host word is valid |
| hostReady | output | 1 | Router can take the host word this cycle |
| busData | output | 32 | Shared value bus to all modules |
| busAddr | output | 8 | Shared register index bus to all modules |
| busSelect | output | 4 | One write strobe per module |
| modReady | input | 4 | Per-module safe-to-write flags |

## Verification
The router is driven with words that target the lowest and highest existing modules under all-ready conditions. These show that the select decode and the field split are right at both ends. Other words target a module that is busy while its neighbours are ready, and a module that is ready while its neighbours are busy. Together they separate a router that follows the addressed module's ready from one that uses some other module's ready or an OR of all of them. Indices at, just above and far above the module count confirm the discard path begins exactly at the boundary. A held write that is released after two busy cycles, and writes presented under reset, show that the strobe appears only in the release cycle and never during reset.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic fwd;   // forward the write to the decoded module
    logic drop;  // accept and discard (index out of range)
  } routeStrobe_t;
endpackage

// File: rtl/cfg_router_ctrl.sv
module cfg_router_ctrl
  import cfg_router_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int MOD_IDX_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hostValid,
  input  logic [MOD_IDX_W-1:0]   modIdx,
  input  logic [NUM_MODULES-1:0] modReady,
  output logic                   hostReady,
  output routeStrobe_t           strobe
);
  localparam logic [MOD_IDX_W-1:0] LAST_IDX = MOD_IDX_W'(NUM_MODULES - 1);

  logic inRange;
  logic targetReady;

  assign inRange = (modIdx <= LAST_IDX);

  always_comb begin
    targetReady = 1'b0;
    for (int k = 0; k < NUM_MODULES; k++) begin
      if (modIdx == MOD_IDX_W'(k)) targetReady = modReady[k];
    end
  end

  always_comb begin
    if (rst)          hostReady = 1'b0;
    else if (inRange) hostReady = targetReady;
    else              hostReady = 1'b1;
  end

  always_comb begin
    strobe.fwd  = hostValid && hostReady && inRange;
    strobe.drop = hostValid && hostReady && !inRange;
  end

  // R8
  rst_holds_host_chk: assert property (@(posedge clk) rst |-> !hostReady);
  // R5
  drop_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !inRange |-> hostReady);
  // R4
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (inRange && !targetReady) |-> (!hostReady && !strobe.fwd));
endmodule

// File: rtl/cfg_router_dp.sv
module cfg_router_dp
  import cfg_router_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int MOD_IDX_W   = 3,
  parameter int REG_IDX_W   = 8,
  parameter int DATA_W      = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [MOD_IDX_W+REG_IDX_W+DATA_W-1:0] hostData,
  input  logic [NUM_MODULES-1:0]                modReady,
  input  logic                                  hostValid,
  input  routeStrobe_t                          strobe,
  output logic [MOD_IDX_W-1:0]                  modIdx,
  output logic [DATA_W-1:0]                     busData,
  output logic [REG_IDX_W-1:0]                  busAddr,
  output logic [NUM_MODULES-1:0]                busSelect
);
  localparam int HOST_W  = MOD_IDX_W + REG_IDX_W + DATA_W;
  localparam int ADDR_LO = DATA_W;
  localparam int MOD_LO  = DATA_W + REG_IDX_W;

  assign busData = hostData[DATA_W-1:0];
  assign busAddr = hostData[MOD_LO-1:ADDR_LO];
  assign modIdx  = hostData[HOST_W-1:MOD_LO];

  for (genvar k = 0; k < NUM_MODULES; k++) begin : g_sel
    assign busSelect[k] = strobe.fwd && (modIdx == MOD_IDX_W'(k));
  end

  // R6
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(busSelect));
  // R9
  select_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (busSelect & ~modReady) == '0);
  // R7
  idle_no_select_chk: assert property (@(posedge clk) disable iff (rst)
    !hostValid |-> (busSelect == '0));
  // R5
  drop_no_select_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.drop |-> (busSelect == '0));
  // R8
  rst_no_select_chk: assert property (@(posedge clk) rst |-> (busSelect == '0));
endmodule

// File: rtl/cfg_bus_router.sv
module cfg_bus_router
  import cfg_router_pkg::*;
#(
  parameter int NUM_MODULES = 4,
  parameter int MOD_IDX_W   = 3,
  parameter int REG_IDX_W   = 8,
  parameter int DATA_W      = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [MOD_IDX_W+REG_IDX_W+DATA_W-1:0] hostData,
  input  logic                                  hostValid,
  output logic                                  hostReady,
  output logic [DATA_W-1:0]                     busData,
  output logic [REG_IDX_W-1:0]                  busAddr,
  output logic [NUM_MODULES-1:0]                busSelect,
  input  logic [NUM_MODULES-1:0]                modReady
);
  routeStrobe_t           strobe;
  logic [MOD_IDX_W-1:0]   modIdx;

  cfg_router_ctrl #(
    .NUM_MODULES(NUM_MODULES), .MOD_IDX_W(MOD_IDX_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .hostValid(hostValid), .modIdx(modIdx),
    .modReady(modReady), .hostReady(hostReady), .strobe(strobe)
  );

  cfg_router_dp #(
    .NUM_MODULES(NUM_MODULES), .MOD_IDX_W(MOD_IDX_W),
    .REG_IDX_W(REG_IDX_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rst(rst), .hostData(hostData), .modReady(modReady),
    .hostValid(hostValid), .strobe(strobe), .modIdx(modIdx),
    .busData(busData), .busAddr(busAddr), .busSelect(busSelect)
  );

  // R2
  select_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    (busSelect != '0) |-> (hostValid && hostReady));
endmodule

// File: tb/test_cfg_bus_router.sv
module test_cfg_bus_router;
  logic        clk = 1'b0;
  logic        rst;
  logic [42:0] hostData;
  logic        hostValid;
  logic        hostReady;
  logic [31:0] busData;
  logic [7:0]  busAddr;
  logic [3:0]  busSelect;
  logic [3:0]  modReady;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_bus_router i_cfg_bus_router (
    .clk(clk), .rst(rst), .hostData(hostData), .hostValid(hostValid),
    .hostReady(hostReady), .busData(busData), .busAddr(busAddr),
    .busSelect(busSelect), .modReady(modReady)
  );

  typedef struct packed {
    logic [2:0]  mIdx;
    logic [7:0]  rIdx;
    logic [31:0] val;
    logic        vld;
    logic [3:0]  rdy;
    logic [3:0]  expSel;
    logic        expRdy;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h11, 32'hA5A5_A5A5, 1'b1, 4'b1111, 4'b0001, 1'b1}, // R1 R2 low end
    '{3'd3, 8'hFF, 32'h0000_0000, 1'b1, 4'b1111, 4'b1000, 1'b1}, // R2 high end
    '{3'd2, 8'h20, 32'h1234_5678, 1'b1, 4'b1011, 4'b0000, 1'b0}, // R4 busy target
    '{3'd2, 8'h21, 32'hDEAD_BEEF, 1'b1, 4'b0100, 4'b0100, 1'b1}, // R3 only target ready
    '{3'd1, 8'h05, 32'h0F0F_0F0F, 1'b0, 4'b1111, 4'b0000, 1'b1}, // R7 idle
    '{3'd5, 8'h33, 32'h5555_AAAA, 1'b1, 4'b0000, 4'b0000, 1'b1}, // R5 above range
    '{3'd7, 8'h44, 32'hFFFF_FFFF, 1'b1, 4'b1111, 4'b0000, 1'b1}, // R5 top index
    '{3'd4, 8'h00, 32'h0000_0001, 1'b1, 4'b1111, 4'b0000, 1'b1}, // R5 boundary
    '{3'd1, 8'h7E, 32'hCAFE_0001, 1'b1, 4'b1101, 4'b0000, 1'b0}  // R9 R3 only target busy
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [7:0] r,
                       input logic [31:0] v, input logic vl, input logic [3:0] rd);
    @(negedge clk);
    hostData  = {m, r, v};
    hostValid = vl;
    modReady  = rd;
    #1;
  endtask

  initial begin
    #100000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; hostData = '0; hostValid = 1'b0; modReady = '0;
    // R8: reset with a valid write to a ready module
    drive(3'd1, 8'h09, 32'h1111_2222, 1'b1, 4'b1111);
    chk("R8", "select in reset", 64'(busSelect), 64'h0);
    chk("R8", "hostReady in reset", 64'(hostReady), 64'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].mIdx, VECS[i].rIdx, VECS[i].val, VECS[i].vld, VECS[i].rdy);
      chk("R2", "select", 64'(busSelect), 64'(VECS[i].expSel));
      chk("R3", "hostReady", 64'(hostReady), 64'(VECS[i].expRdy));
      chk("R1", "busAddr", 64'(busAddr), 64'(VECS[i].rIdx));
      chk("R1", "busData", 64'(busData), 64'(VECS[i].val));
      chk("R6", "select count", 64'($countones(busSelect) <= 1), 64'h1);
    end

    // R4: hold a write to module 3 while it is busy, then release
    for (int c = 0; c < 2; c++) begin
      drive(3'd3, 8'h40, 32'hBEEF_0003, 1'b1, 4'b0111);
      chk("R4", "stalled select", 64'(busSelect), 64'h0);
      chk("R4", "stalled hostReady", 64'(hostReady), 64'h0);
    end
    drive(3'd3, 8'h40, 32'hBEEF_0003, 1'b1, 4'b1111);
    chk("R4", "release select", 64'(busSelect), 64'h8);
    chk("R4", "release hostReady", 64'(hostReady), 64'h1);

    // R9: target busy, all others ready, nothing strobed
    drive(3'd0, 8'h01, 32'h0, 1'b1, 4'b1110);
    chk("R9", "busy module 0 select", 64'(busSelect), 64'h0);

    // R8: reset reasserted mid-stream
    @(negedge clk); rst = 1'b1;
    drive(3'd2, 8'h02, 32'h2, 1'b1, 4'b1111);
    chk("R8", "select in second reset", 64'(busSelect), 64'h0);
    chk("R8", "hostReady in second reset", 64'(hostReady), 64'h0);
    @(negedge clk); rst = 1'b0;
    drive(3'd2, 8'h02, 32'h2, 1'b1, 4'b1111);
    chk("R2", "select after reset", 64'(busSelect), 64'h4);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule